// File: doc/BRIEF.md
# Paged MDIO Indirect Bus Bridge

This block sits behind the register file of a slave MDIO port, where every access moves one 16-bit word at a 5-bit register number. It lets that narrow host reach an internal bus with 32-bit addresses and 32-bit data. A page register picks which bank is visible in the upper register range. When the window page is selected, nine registers form an indirect access window:

- a mode register;
- a write-address pair, a write-data pair and a read-address pair, each split into upper and lower halves;
- a read-data pair.

A write is committed when the lower data half arrives. A read is launched when the lower read-address half arrives. The internal side is a single valid/ready request port. Read results come back on a separate response strobe.

In increment mode, the host loads a start address once and then streams high/low data pairs. Each pair lands one word further on, which makes it practical to push a large image such as firmware through a slow management link. The host can watch the busy flag to pace itself. A second command that arrives while the first is still waiting on the bus is parked in a one-deep slot and issued in order.

Top module: `mdio_page_bridge`

## Requirements
- R1: After reset:
  - the page register (0x1F) reads 0;
  - every window register reads 0;
  - `req_valid` and `busy` are low.
- R2: Register 0x1F can be written and read back on every page. Its value selects the page that is visible.
- R3: While the page is not `WIN_PAGE` (default 4), registers 0x10 to 0x18 read as zero and ignore writes. Once the window page is selected, those registers still hold their earlier contents.
- R4: On the window page:
  - 0x11 holds bits 31:16 of the write address and 0x12 holds bits 15:0; both read back as written.
  - 0x15 holds bits 31:16 of the read address and 0x16 holds bits 15:0; both read back as written.
- R5: A write to 0x13 (upper write-data half) only latches the value. It raises no bus request.
- R6: A write to 0x14 (lower write-data half) commits a bus write in the next cycle:
  - `req_write` is 1;
  - `req_addr` is the write address;
  - `req_wdata` is {0x13 value, 0x14 value}.
- R7: When bit 15 of mode register 0x10 is 0, a commit leaves the write address unchanged.
- R8: When bit 15 of 0x10 is 1, each commit advances the write address by `STEP_BYTES` (default 4). Consecutive data pairs therefore go to consecutive words, and 0x11/0x12 read back the advanced address.
- R9: A write to 0x16 launches a bus read of {0x15, low half just written}. When the response arrives:
  - its bits 31:16 read back at 0x17;
  - its bits 15:0 read back at 0x18;
  - both stay unchanged until the next read response, even if bus writes happen in between.
- R10: `busy` is high while a request is waiting on the bus, a command is parked, or a read response is owed. A command arriving while the bus has not yet taken the previous one is held and issued after it, in order.
- R11: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_write`, `req_addr` and `req_wdata` hold steady.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Host register write strobe |
| reg_addr | input | 5 | Host register number |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Read data for the register at `reg_addr` (combinational) |
| busy | output | 1 | Internal transaction in flight |
| req_valid | output | 1 | Internal bus request valid |
| req_ready | input | 1 | Internal bus accepts the request |
| req_write | output | 1 | 1 for write, 0 for read |
| req_addr | output | 32 | Internal bus byte address |
| req_wdata | output | 32 | Internal bus write data |
| rsp_valid | input | 1 | Read response strobe |
| rsp_rdata | input | 32 | Read response data |

## Verification
The bench uses the default parameters: window page 4, a 16-bit page register, a 4-byte increment step and bit 15 as the increment flag. With these values, the tests reach:
- off-page writes to the window range;
- a three-word increment burst whose last step is visible through the address readback;
- back-to-back commits that stall behind a deasserted ready, which fills the parked slot.

The bus model answers every read one cycle after acceptance, with data derived from the address. Read data can therefore be predicted without looking into the design.

// File: rtl/mdio_bridge_pkg.sv
package mdio_bridge_pkg;
   localparam int HALF_W = 16;
   localparam int WORD_W = 2 * HALF_W;
   localparam int REG_AW = 5;

   // window register numbers; the host decodes these positions
   localparam logic [REG_AW-1:0] OFS_MODE  = 5'h10;
   localparam logic [REG_AW-1:0] OFS_WA_HI = 5'h11;
   localparam logic [REG_AW-1:0] OFS_WA_LO = 5'h12;
   localparam logic [REG_AW-1:0] OFS_WD_HI = 5'h13;
   localparam logic [REG_AW-1:0] OFS_WD_LO = 5'h14;
   localparam logic [REG_AW-1:0] OFS_RA_HI = 5'h15;
   localparam logic [REG_AW-1:0] OFS_RA_LO = 5'h16;
   localparam logic [REG_AW-1:0] OFS_RD_HI = 5'h17;
   localparam logic [REG_AW-1:0] OFS_RD_LO = 5'h18;
   localparam logic [REG_AW-1:0] OFS_PAGE  = 5'h1F;
endpackage

// File: rtl/mdio_win_regs.sv
module mdio_win_regs
   import mdio_bridge_pkg::*;
#(
   parameter int PAGE_W     = 16,
   parameter int WIN_PAGE   = 4,
   parameter int STEP_BYTES = 4,
   parameter int INC_BIT    = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [HALF_W-1:0] reg_wdata,
   output logic [HALF_W-1:0] reg_rdata,
   input  logic [WORD_W-1:0] rd_word_i,
   output logic              wr_cmd_o,
   output logic              rd_cmd_o,
   output logic [WORD_W-1:0] cmd_addr_o,
   output logic [WORD_W-1:0] cmd_data_o
);
   localparam logic [PAGE_W-1:0] WIN_ID = PAGE_W'(WIN_PAGE);
   localparam logic [WORD_W-1:0] STEP   = WORD_W'(STEP_BYTES);

   logic [PAGE_W-1:0] page_q;
   logic              inc_q;
   logic [HALF_W-1:0] wd_hi_q, wd_lo_q;
   logic [WORD_W-1:0] pair_addr [2];
   logic              win_sel, hit_we, in_range;

   assign win_sel  = (page_q == WIN_ID);
   assign hit_we   = reg_we && win_sel;
   assign in_range = (reg_addr >= OFS_MODE) && (reg_addr <= OFS_RD_LO);
   assign wr_cmd_o = hit_we && (reg_addr == OFS_WD_LO);
   assign rd_cmd_o = hit_we && (reg_addr == OFS_RA_LO);
   assign cmd_data_o = {wd_hi_q, reg_wdata};
   assign cmd_addr_o = rd_cmd_o ? {pair_addr[1][WORD_W-1:HALF_W], reg_wdata}
                                : pair_addr[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         page_q  <= '0;
         inc_q   <= 1'b0;
         wd_hi_q <= '0;
         wd_lo_q <= '0;
      end else begin
         if (reg_we && reg_addr == OFS_PAGE) page_q <= reg_wdata[PAGE_W-1:0];
         if (hit_we && reg_addr == OFS_MODE) inc_q <= reg_wdata[INC_BIT];
         if (hit_we && reg_addr == OFS_WD_HI) wd_hi_q <= reg_wdata;
         if (wr_cmd_o) wd_lo_q <= reg_wdata;
      end
   end

   // index 0: write address pair, index 1: read address pair
   for (genvar g = 0; g < 2; g++) begin : g_addr_pair
      localparam logic [REG_AW-1:0] HI_OFS = (g == 0) ? OFS_WA_HI : OFS_RA_HI;
      localparam logic [REG_AW-1:0] LO_OFS = (g == 0) ? OFS_WA_LO : OFS_RA_LO;
      localparam bit CAN_STEP = (g == 0);
      logic [HALF_W-1:0] hi_q, lo_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
         end else if (hit_we && reg_addr == HI_OFS) begin
            hi_q <= reg_wdata;
         end else if (hit_we && reg_addr == LO_OFS) begin
            lo_q <= reg_wdata;
         end else if (CAN_STEP && wr_cmd_o && inc_q) begin
            {hi_q, lo_q} <= {hi_q, lo_q} + STEP;
         end
      end
      assign pair_addr[g] = {hi_q, lo_q};
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == OFS_PAGE) begin
         reg_rdata = HALF_W'(page_q);
      end else if (win_sel) begin
         case (reg_addr)
            OFS_MODE:  reg_rdata[INC_BIT] = inc_q;
            OFS_WA_HI: reg_rdata = pair_addr[0][WORD_W-1:HALF_W];
            OFS_WA_LO: reg_rdata = pair_addr[0][HALF_W-1:0];
            OFS_WD_HI: reg_rdata = wd_hi_q;
            OFS_WD_LO: reg_rdata = wd_lo_q;
            OFS_RA_HI: reg_rdata = pair_addr[1][WORD_W-1:HALF_W];
            OFS_RA_LO: reg_rdata = pair_addr[1][HALF_W-1:0];
            OFS_RD_HI: reg_rdata = rd_word_i[WORD_W-1:HALF_W];
            OFS_RD_LO: reg_rdata = rd_word_i[HALF_W-1:0];
            default:   reg_rdata = '0;
         endcase
      end
   end

   // R8
   inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cmd_o && inc_q) |=> (pair_addr[0] == $past(pair_addr[0]) + STEP));
   // R7
   fixed_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cmd_o && !inc_q) |=> $stable(pair_addr[0]));
   // R3
   off_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && !win_sel && in_range) |=>
         ($stable(inc_q) && $stable(wd_hi_q) && $stable(wd_lo_q) &&
          $stable(pair_addr[0]) && $stable(pair_addr[1])));
endmodule

// File: rtl/mdio_cmd_queue.sv
module mdio_cmd_queue #(
   parameter int AW = 32,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_cmd_i,
   input  logic          rd_cmd_i,
   input  logic [AW-1:0] cmd_addr_i,
   input  logic [DW-1:0] cmd_data_i,
   output logic          req_valid,
   input  logic          req_ready,
   output logic          req_write,
   output logic [AW-1:0] req_addr,
   output logic [DW-1:0] req_wdata,
   input  logic          rsp_valid,
   input  logic [DW-1:0] rsp_rdata,
   output logic [DW-1:0] rd_word_o,
   output logic          busy_o
);
   logic          act_v, act_wr, pend_v, pend_wr, rd_wait;
   logic [AW-1:0] act_addr, pend_addr;
   logic [DW-1:0] act_data, pend_data;
   logic          new_cmd, accept, take_now;

   assign new_cmd  = wr_cmd_i || rd_cmd_i;
   assign accept   = act_v && req_ready;
   assign take_now = !act_v || (accept && !pend_v);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_v <= 1'b0; act_wr <= 1'b0; act_addr <= '0; act_data <= '0;
         pend_v <= 1'b0; pend_wr <= 1'b0; pend_addr <= '0; pend_data <= '0;
         rd_wait <= 1'b0; rd_word_o <= '0;
      end else begin
         if (accept) begin
            act_v    <= pend_v;
            act_wr   <= pend_wr;
            act_addr <= pend_addr;
            act_data <= pend_data;
            pend_v   <= 1'b0;
         end
         if (new_cmd) begin
            if (take_now) begin
               act_v    <= 1'b1;
               act_wr   <= wr_cmd_i;
               act_addr <= cmd_addr_i;
               act_data <= cmd_data_i;
            end else begin
               pend_v    <= 1'b1;
               pend_wr   <= wr_cmd_i;
               pend_addr <= cmd_addr_i;
               pend_data <= cmd_data_i;
            end
         end
         if (accept && !act_wr) rd_wait <= 1'b1;
         else if (rsp_valid)    rd_wait <= 1'b0;
         if (rsp_valid) rd_word_o <= rsp_rdata;
      end
   end

   assign req_valid = act_v;
   assign req_write = act_wr;
   assign req_addr  = act_addr;
   assign req_wdata = act_data;
   assign busy_o    = act_v || pend_v || rd_wait;

   // R11
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=>
         (req_valid && $stable(req_addr) && $stable(req_write) && $stable(req_wdata)));
   // R10
   park_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && pend_v) |=> (req_valid && req_addr == $past(pend_addr)));
   // R6
   issue_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      new_cmd |=> busy_o);
   // R9
   rsp_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> (rd_word_o == $past(rsp_rdata)));
endmodule

// File: rtl/mdio_page_bridge.sv
module mdio_page_bridge
   import mdio_bridge_pkg::*;
#(
   parameter int PAGE_W     = 16,
   parameter int WIN_PAGE   = 4,
   parameter int STEP_BYTES = 4,
   parameter int INC_BIT    = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [HALF_W-1:0] reg_wdata,
   output logic [HALF_W-1:0] reg_rdata,
   output logic              busy,
   output logic              req_valid,
   input  logic              req_ready,
   output logic              req_write,
   output logic [WORD_W-1:0] req_addr,
   output logic [WORD_W-1:0] req_wdata,
   input  logic              rsp_valid,
   input  logic [WORD_W-1:0] rsp_rdata
);
   if (PAGE_W < 1 || PAGE_W > HALF_W) begin : g_bad_page_w
      $error("PAGE_W must be 1..16");
   end
   if (WIN_PAGE < 0 || WIN_PAGE >= (1 << PAGE_W)) begin : g_bad_win
      $error("WIN_PAGE does not fit in PAGE_W bits");
   end
   if (STEP_BYTES < 1) begin : g_bad_step
      $error("STEP_BYTES must be positive");
   end
   if (INC_BIT < 0 || INC_BIT >= HALF_W) begin : g_bad_inc
      $error("INC_BIT must lie inside a 16-bit word");
   end

   logic              wr_cmd, rd_cmd;
   logic [WORD_W-1:0] cmd_addr, cmd_data, rd_word;

   mdio_win_regs #(
      .PAGE_W(PAGE_W), .WIN_PAGE(WIN_PAGE),
      .STEP_BYTES(STEP_BYTES), .INC_BIT(INC_BIT)
   ) regs_i (
      .clk(clk), .rst_n(rst_n),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .rd_word_i(rd_word),
      .wr_cmd_o(wr_cmd), .rd_cmd_o(rd_cmd),
      .cmd_addr_o(cmd_addr), .cmd_data_o(cmd_data)
   );

   mdio_cmd_queue #(.AW(WORD_W), .DW(WORD_W)) queue_i (
      .clk(clk), .rst_n(rst_n),
      .wr_cmd_i(wr_cmd), .rd_cmd_i(rd_cmd),
      .cmd_addr_i(cmd_addr), .cmd_data_i(cmd_data),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .rd_word_o(rd_word), .busy_o(busy)
   );
endmodule

// File: tb/mdio_page_bridge_tb.sv
module mdio_page_bridge_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        busy, req_valid, req_write;
   logic        req_ready = 1'b0;
   logic [31:0] req_addr, req_wdata;
   logic        rsp_valid = 1'b0;
   logic [31:0] rsp_rdata = '0;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   logic [31:0] log_addr [64];
   logic [31:0] log_data [64];
   logic        log_wr   [64];
   int          log_n = 0;
   logic        rsp_due = 1'b0;
   logic [31:0] rsp_due_data = '0;

   always #2.5 clk = ~clk;

   mdio_page_bridge dut_i (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
   );

   function automatic logic [31:0] model_word(input logic [31:0] a);
      return {a[15:0], a[31:16] ^ 16'h5A5A};
   endfunction

   // bus model: logs accepted requests, answers reads one cycle later
   always @(negedge clk) begin
      rsp_valid = rsp_due;
      rsp_rdata = rsp_due_data;
      rsp_due   = 1'b0;
      #2;
      if (rst_n && req_valid && req_ready && log_n < 64) begin
         log_addr[log_n] = req_addr;
         log_data[log_n] = req_wdata;
         log_wr[log_n]   = req_write;
         log_n++;
         if (!req_write) begin
            rsp_due      = 1'b1;
            rsp_due_data = model_word(req_addr);
         end
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [15:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic t_reset;
      logic [15:0] v;
      rd(5'h1F, v);
      chk(v == 16'h0, "R1", "page after reset", 32'(v), 32'h0);
      chk(!busy && !req_valid, "R1", "busy/req_valid after reset",
          {30'h0, busy, req_valid}, 32'h0);
   endtask

   task automatic t_page;
      logic [15:0] v;
      wr(5'h1F, 16'h0007);
      rd(5'h1F, v);
      chk(v == 16'h0007, "R2", "page readback", 32'(v), 32'h7);
      wr(5'h1F, 16'h0004);
      rd(5'h1F, v);
      chk(v == 16'h0004, "R2", "page readback from other page", 32'(v), 32'h4);
      wr(5'h1F, 16'h0000);
   endtask

   task automatic t_offpage;
      logic [15:0] v;
      wr(5'h1F, 16'h0000);
      wr(5'h11, 16'hBEEF);
      wr(5'h10, 16'h8000);
      rd(5'h11, v);
      chk(v == 16'h0, "R3", "off-page read of 0x11", 32'(v), 32'h0);
      wr(5'h14, 16'h1111);
      idle(2);
      chk(log_n == 0 && !busy, "R3", "off-page data write raised request",
          32'(log_n), 32'h0);
      wr(5'h1F, 16'h0004);
      rd(5'h11, v);
      chk(v == 16'h0, "R3", "0x11 after off-page write", 32'(v), 32'h0);
      rd(5'h10, v);
      chk(v == 16'h0, "R1", "mode register zero", 32'(v), 32'h0);
   endtask

   task automatic t_halves;
      logic [15:0] v;
      wr(5'h11, 16'h1234);
      wr(5'h12, 16'h5678);
      rd(5'h11, v);
      chk(v == 16'h1234, "R4", "write addr upper", 32'(v), 32'h1234);
      rd(5'h12, v);
      chk(v == 16'h5678, "R4", "write addr lower", 32'(v), 32'h5678);
      wr(5'h15, 16'h9ABC);
      rd(5'h15, v);
      chk(v == 16'h9ABC, "R4", "read addr upper", 32'(v), 32'h9ABC);
   endtask

   task automatic t_write_fixed;
      logic [15:0] v;
      int s;
      req_ready = 1'b1;
      wr(5'h10, 16'h0000);
      wr(5'h11, 16'h0010);
      wr(5'h12, 16'h0000);
      s = log_n;
      wr(5'h13, 16'hDEAD);
      idle(3);
      chk(log_n == s && !req_valid, "R5", "high half raised request",
          32'(log_n - s), 32'h0);
      wr(5'h14, 16'hBEEF);
      idle(3);
      chk(log_n == s + 1 && log_wr[s] == 1'b1, "R6", "one write issued",
          32'(log_n - s), 32'h1);
      chk(log_addr[s] == 32'h0010_0000, "R6", "write address",
          log_addr[s], 32'h0010_0000);
      chk(log_data[s] == 32'hDEAD_BEEF, "R6", "write data",
          log_data[s], 32'hDEAD_BEEF);
      wr(5'h13, 16'h0102);
      wr(5'h14, 16'h0304);
      idle(3);
      chk(log_addr[s+1] == 32'h0010_0000, "R7", "fixed mode second address",
          log_addr[s+1], 32'h0010_0000);
      rd(5'h12, v);
      chk(v == 16'h0000, "R7", "address lower unchanged", 32'(v), 32'h0);
   endtask

   task automatic t_write_inc;
      logic [15:0] v;
      int s;
      req_ready = 1'b1;
      wr(5'h10, 16'h8000);
      rd(5'h10, v);
      chk(v == 16'h8000, "R8", "mode readback", 32'(v), 32'h8000);
      wr(5'h11, 16'h0000);
      wr(5'h12, 16'h0100);
      s = log_n;
      for (int k = 0; k < 3; k++) begin
         wr(5'h13, 16'hA000 + 16'(k));
         wr(5'h14, 16'h0B00 + 16'(k));
      end
      idle(3);
      chk(log_n == s + 3, "R8", "burst word count", 32'(log_n - s), 32'h3);
      for (int k = 0; k < 3; k++) begin
         chk(log_addr[s+k] == 32'h100 + 32'(4 * k), "R8", "burst address",
             log_addr[s+k], 32'h100 + 32'(4 * k));
         chk(log_data[s+k] == {16'hA000 + 16'(k), 16'h0B00 + 16'(k)}, "R8",
             "burst data", log_data[s+k], {16'hA000 + 16'(k), 16'h0B00 + 16'(k)});
      end
      rd(5'h12, v);
      chk(v == 16'h010C, "R8", "advanced address readback", 32'(v), 32'h10C);
      wr(5'h10, 16'h0000);
   endtask

   task automatic t_backpressure;
      int s;
      req_ready = 1'b0;
      wr(5'h11, 16'h0000);
      wr(5'h12, 16'h0200);
      s = log_n;
      wr(5'h13, 16'h1111);
      wr(5'h14, 16'h2222);
      chk(busy && req_valid, "R10", "busy while waiting", {30'h0, busy, req_valid}, 32'h3);
      wr(5'h13, 16'h3333);
      wr(5'h14, 16'h4444);
      idle(2);
      chk(req_valid && req_addr == 32'h200 && req_wdata == 32'h1111_2222, "R11",
          "stalled request held", req_wdata, 32'h1111_2222);
      @(negedge clk);
      req_ready = 1'b1;
      idle(4);
      chk(log_n == s + 2, "R10", "both commits issued", 32'(log_n - s), 32'h2);
      chk(log_data[s] == 32'h1111_2222 && log_data[s+1] == 32'h3333_4444, "R10",
          "issue order", log_data[s+1], 32'h3333_4444);
      chk(!busy, "R10", "busy clears", {31'h0, busy}, 32'h0);
   endtask

   task automatic t_read;
      logic [15:0] v;
      logic [31:0] exp;
      int s;
      req_ready = 1'b1;
      exp = model_word(32'h00AB_CDEF);
      s = log_n;
      wr(5'h15, 16'h00AB);
      wr(5'h16, 16'hCDEF);
      idle(5);
      chk(log_n == s + 1 && !log_wr[s] && log_addr[s] == 32'h00AB_CDEF, "R9",
          "read request address", log_addr[s], 32'h00AB_CDEF);
      rd(5'h17, v);
      chk(v == exp[31:16], "R9", "read data upper", 32'(v), 32'(exp[31:16]));
      rd(5'h18, v);
      chk(v == exp[15:0], "R9", "read data lower", 32'(v), 32'(exp[15:0]));
      chk(!busy, "R10", "busy clears after response", {31'h0, busy}, 32'h0);
      wr(5'h13, 16'h5555);
      wr(5'h14, 16'h6666);
      idle(3);
      rd(5'h18, v);
      chk(v == exp[15:0], "R9", "read data held across write", 32'(v), 32'(exp[15:0]));
   endtask

   initial begin
      #1_000_000;
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      idle(3);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_page();
      t_offpage();
      t_halves();
      t_write_fixed();
      t_write_inc();
      t_backpressure();
      t_read();
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule